// File: doc/BRIEF.md
# Dual-Mode LED Serial Loader

This block is the serial input stage of a 16-channel LED driver. A single shift chain captures one bit per rising edge of the serial clock, most significant bit first. A mode pin selects what the chain carries: a 96-bit packet of 6-bit brightness-correction values, or a 192-bit packet of 12-bit intensity values. A rising edge on the latch strobe copies the chain into the holding register of the current mode. The serial output shows the oldest bit of the active chain length, so several devices can be wired in series.

The latched 12-bit intensity values drive a per-channel PWM comparator. A shared counter advances on each rising edge of a grayscale clock. A blanking input clears the counter and turns every output off. All strobes are sampled in the `clk_i` domain, and only their rising edges act.

Top module: `led_serial_loader`

## Requirements
- R1: After reset, `sout_o`, `dc_o`, `gs_o` and `pwm_o` are all zero.
- R2: The chain shifts exactly once for each low-to-high transition seen on `sclk_i`. `sclk_i` held high does not shift it again. The new bit enters at bit 0, so the first bit sent ends up highest.
- R3: With `mode_i` low, a rising edge of `xlat_i` copies all 192 chain bits to `gs_o`. Channel n is `gs_o[12n+11:12n]`, and the first bit sent is bit 191 (the MSB of channel 15).
- R4: With `mode_i` high, a rising edge of `xlat_i` copies the 96 chain bits sent last to `dc_o`. Channel 0 is `dc_o[5:0]` and channel 15 is `dc_o[95:90]`.
- R5: A latch in one mode leaves the holding register of the other mode unchanged.
- R6: `xlat_i` held high latches once only. Data shifted in while it stays high is not transferred until the next rising edge.
- R7: `sout_o` is chain bit 191 when `mode_i` is low and chain bit 95 when `mode_i` is high. It therefore shows the bit that entered 192 (or 96) shifts earlier.
- R8: The grayscale counter starts at 0 and advances by one on each rising edge of `gsclk_i`. After 4094 it returns to 0.
- R9: `pwm_o[n]` is 1 while the counter is below channel n's latched value. A value of 0 is never on, and a value of 4095 is always on.
- R10: While `blank_i` is high, `pwm_o` is all zero and the counter is held at 0, so counting restarts from 0 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial shift strobe, acts on rising edge |
| sin_i | input | 1 | Serial data in |
| mode_i | input | 1 | 1: correction packet (96 bits), 0: intensity packet (192 bits) |
| xlat_i | input | 1 | Latch strobe, acts on rising edge |
| gsclk_i | input | 1 | Grayscale counter strobe, acts on rising edge |
| blank_i | input | 1 | Clears the counter and forces outputs off |
| sout_o | output | 1 | Serial data out for cascading |
| dc_o | output | 96 | Latched correction values, 6 bits per channel |
| gs_o | output | 192 | Latched intensity values, 12 bits per channel |
| pwm_o | output | 16 | Per-channel PWM outputs |

## Verification
The hardest conditions to reach are the counter's wrap point and the single-edge behaviour of held strobes. The first takes 4094 grayscale strobes, sent against a packet whose channels sit at 0, 3, 4094 and 4095, so each compare boundary becomes visible on `pwm_o`. For the second, `sclk_i` is held high over several cycles with a lone 1 behind zeros; after exactly 96 further shifts the serial output must drop, which exposes any repeated shift. A latch strobe is also held high across a whole packet, and the holding register must not change until a second rising edge.

// File: rtl/led_loader_pkg.sv
package led_loader_pkg;
  typedef enum logic {
    MODE_GS = 1'b0,
    MODE_DC = 1'b1
  } mode_e;
endpackage

// File: rtl/led_edge_det.sv
module led_edge_det #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[i] <= 1'b0;
      else         prev_q[i] <= d_i[i];
    end
    assign rise_o[i] = d_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/led_shift_chain.sv
module led_shift_chain
  import led_loader_pkg::*;
#(
  parameter int unsigned LONG_LEN  = 192,
  parameter int unsigned SHORT_LEN = 96
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_i,
  input  logic                sin_i,
  input  mode_e               mode_i,
  output logic [LONG_LEN-1:0] chain_o,
  output logic                sout_o
);
  logic [LONG_LEN-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[LONG_LEN-2:0], sin_i};
  end

  // tap point follows effective chain length
  assign sout_o  = (mode_i == MODE_DC) ? sr_q[SHORT_LEN-1] : sr_q[LONG_LEN-1];
  assign chain_o = sr_q;
endmodule

// File: rtl/led_hold_reg.sv
module led_hold_reg #(
  parameter int unsigned W = 96
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/led_pwm.sv
module led_pwm #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned GS_W   = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   step_i,
  input  logic                   blank_i,
  input  logic [NUM_CH*GS_W-1:0] gs_i,
  output logic [GS_W-1:0]        cnt_o,
  output logic [NUM_CH-1:0]      pwm_o
);
  // period of 2^GS_W-1 steps so full scale stays on
  localparam logic [GS_W-1:0] CNT_MAX = GS_W'((1 << GS_W) - 2);

  logic [GS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (blank_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign pwm_o[n] = ~blank_i & (cnt_q < gs_i[n*GS_W +: GS_W]);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/led_serial_loader.sv
module led_serial_loader
  import led_loader_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned DC_W   = 6,
  parameter int unsigned GS_W   = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   sin_i,
  input  logic                   mode_i,
  input  logic                   xlat_i,
  input  logic                   gsclk_i,
  input  logic                   blank_i,
  output logic                   sout_o,
  output logic [NUM_CH*DC_W-1:0] dc_o,
  output logic [NUM_CH*GS_W-1:0] gs_o,
  output logic [NUM_CH-1:0]      pwm_o
);
  localparam int unsigned DC_LEN = NUM_CH * DC_W;
  localparam int unsigned GS_LEN = NUM_CH * GS_W;

  logic [2:0]        rise;
  logic              sclk_rise, xlat_rise, gsclk_rise;
  logic [GS_LEN-1:0] chain;
  logic [GS_W-1:0]   gs_cnt;
  mode_e             mode;

  assign mode = mode_e'(mode_i);

  led_edge_det #(.N(3)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({gsclk_i, xlat_i, sclk_i}),
    .rise_o (rise)
  );
  assign sclk_rise  = rise[0];
  assign xlat_rise  = rise[1];
  assign gsclk_rise = rise[2];

  led_shift_chain #(.LONG_LEN(GS_LEN), .SHORT_LEN(DC_LEN)) i_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (sclk_rise),
    .sin_i   (sin_i),
    .mode_i  (mode),
    .chain_o (chain),
    .sout_o  (sout_o)
  );

  led_hold_reg #(.W(DC_LEN)) i_dc_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (xlat_rise && mode == MODE_DC),
    .d_i    (chain[DC_LEN-1:0]),
    .q_o    (dc_o)
  );

  led_hold_reg #(.W(GS_LEN)) i_gs_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (xlat_rise && mode == MODE_GS),
    .d_i    (chain),
    .q_o    (gs_o)
  );

  led_pwm #(.NUM_CH(NUM_CH), .GS_W(GS_W)) i_pwm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (gsclk_rise),
    .blank_i (blank_i),
    .gs_i    (gs_o),
    .cnt_o   (gs_cnt),
    .pwm_o   (pwm_o)
  );
endmodule

// File: rtl/led_serial_loader_chk.sv
module led_serial_loader_chk #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned DC_W   = 6,
  parameter int unsigned GS_W   = 12
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   sclk_i,
  input logic                   mode_i,
  input logic                   xlat_i,
  input logic                   gsclk_i,
  input logic                   blank_i,
  input logic                   sout_o,
  input logic [NUM_CH*DC_W-1:0] dc_o,
  input logic [NUM_CH*GS_W-1:0] gs_o,
  input logic [GS_W-1:0]        cnt_i
);
  localparam logic [GS_W-1:0] LIMIT = GS_W'((1 << GS_W) - 2);

  logic sclk_p, xlat_p, gsclk_p;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) {sclk_p, xlat_p, gsclk_p} <= '0;
    else         {sclk_p, xlat_p, gsclk_p} <= {sclk_i, xlat_i, gsclk_i};
  end

  AST_DC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xlat_i && !xlat_p && mode_i) |=> $stable(dc_o)); // R5
  AST_GS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xlat_i && !xlat_p && !mode_i) |=> $stable(gs_o)); // R5
  AST_SOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sclk_i && !sclk_p) |=> (sout_o == $past(sout_o)) || (mode_i != $past(mode_i))); // R2
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gsclk_i && !gsclk_p) && !blank_i |=> $stable(cnt_i)); // R8
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= LIMIT); // R8
  AST_BLANK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |=> cnt_i == '0); // R10
endmodule

bind led_serial_loader led_serial_loader_chk #(
  .NUM_CH(NUM_CH), .DC_W(DC_W), .GS_W(GS_W)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sclk_i  (sclk_i),
  .mode_i  (mode_i),
  .xlat_i  (xlat_i),
  .gsclk_i (gsclk_i),
  .blank_i (blank_i),
  .sout_o  (sout_o),
  .dc_o    (dc_o),
  .gs_o    (gs_o),
  .cnt_i   (gs_cnt)
);

// File: tb/test_led_serial_loader.sv
module test_led_serial_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 0, sin = 0, mode = 0, xlat = 0, gsclk = 0, blank = 0;
  logic        sout;
  logic [95:0]  dc;
  logic [191:0] gs;
  logic [15:0]  pwm;

  int checks = 0;
  int fails  = 0;

  logic [191:0] sr_m = '0, gs_m = '0;
  logic [95:0]  dc_m = '0;

  // {mode, seed}
  localparam logic [12:0] VEC [4] = '{
    {1'b0, 12'hABC}, {1'b1, 12'h015}, {1'b0, 12'hFFF}, {1'b1, 12'h03F}
  };

  always #10 clk = ~clk;

  led_serial_loader i_led_serial_loader (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sin_i(sin), .mode_i(mode),
    .xlat_i(xlat), .gsclk_i(gsclk), .blank_i(blank), .sout_o(sout),
    .dc_o(dc), .gs_o(gs), .pwm_o(pwm)
  );

  task automatic chk(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk); sin = b; sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
    sr_m = {sr_m[190:0], b};
  endtask

  task automatic latch();
    @(negedge clk); xlat = 1'b1;
    @(negedge clk); xlat = 1'b0;
    if (mode) dc_m = sr_m[95:0]; else gs_m = sr_m;
  endtask

  task automatic gs_step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); gsclk = 1'b1;
      @(negedge clk); gsclk = 1'b0;
    end
  endtask

  function automatic logic [191:0] gs_pkt(input logic [11:0] seed);
    logic [191:0] p;
    for (int n = 0; n < 16; n++) p[12*n +: 12] = seed + 12'(n * 291);
    return p;
  endfunction

  function automatic logic [95:0] dc_pkt(input logic [5:0] seed);
    logic [95:0] p;
    for (int n = 0; n < 16; n++) p[6*n +: 6] = seed + 6'(n * 7);
    return p;
  endfunction

  task automatic chk_sout(input string req);
    logic e;
    e = mode ? sr_m[95] : sr_m[191];
    chk(sout === e, req, {191'b0, sout}, {191'b0, e});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [191:0] p;
    logic [95:0]  d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sout === 1'b0, "R1 sout", {191'b0, sout}, '0);
    chk(dc === '0, "R1 dc", {96'b0, dc}, '0);
    chk(gs === '0, "R1 gs", gs, '0);
    chk(pwm === '0, "R1 pwm", {176'b0, pwm}, '0);

    // table of packets, alternating modes
    foreach (VEC[k]) begin
      @(negedge clk); mode = VEC[k][12];
      @(negedge clk);
      chk_sout("R7 tap after mode select");
      if (mode) begin
        d = dc_pkt(VEC[k][5:0]);
        for (int i = 95; i >= 0; i--) shift_bit(d[i]);
        chk(sout === d[95], "R7 dc sout first bit", {191'b0, sout}, {191'b0, d[95]});
      end else begin
        p = gs_pkt(VEC[k][11:0]);
        for (int i = 191; i >= 0; i--) shift_bit(p[i]);
        chk(sout === p[191], "R7 gs sout first bit", {191'b0, sout}, {191'b0, p[191]});
      end
      latch();
      @(negedge clk);
      chk(dc === dc_m, "R4 R5 dc register", {96'b0, dc}, {96'b0, dc_m});
      chk(gs === gs_m, "R3 R5 gs register", gs, gs_m);
    end
    chk(gs[191:180] === 12'hFFF + 12'(15 * 291), "R3 ch15 field", {180'b0, gs[191:180]}, {180'b0, 12'hFFF + 12'(15 * 291)});
    chk(dc[5:0] === 6'h3F && dc[95:90] === 6'h3F + 6'(105), "R4 ch0 ch15 fields", {96'b0, dc}, {96'b0, dc_m});

    // R2: held sclk shifts once
    @(negedge clk); mode = 1'b1; sin = 1'b1; sclk = 1'b1;
    repeat (5) @(negedge clk);
    sclk = 1'b0; sr_m = {sr_m[190:0], 1'b1};
    for (int i = 0; i < 95; i++) shift_bit(1'b0);
    chk(sout === 1'b1, "R2 single shift marker", {191'b0, sout}, 192'd1);
    shift_bit(1'b0);
    chk(sout === 1'b0, "R2 no extra shift", {191'b0, sout}, '0);

    // R6: held xlat latches once
    @(negedge clk); mode = 1'b0;
    @(negedge clk); xlat = 1'b1; gs_m = sr_m;
    @(negedge clk);
    chk(gs === gs_m, "R6 first edge latches", gs, gs_m);
    p = gs_pkt(12'h5A5);
    for (int i = 191; i >= 0; i--) shift_bit(p[i]);
    chk(gs === gs_m, "R6 held high no relatch", gs, gs_m);
    @(negedge clk); xlat = 1'b0;
    @(negedge clk);
    chk(gs === gs_m, "R6 falling edge no latch", gs, gs_m);
    latch();
    @(negedge clk);
    chk(gs === p, "R6 second edge latches", gs, p);

    // PWM boundaries: ch0=0, ch1=4095, ch2=3, ch15=4094
    p = '0;
    p[23:12] = 12'hFFF; p[35:24] = 12'd3; p[191:180] = 12'd4094;
    for (int i = 191; i >= 0; i--) shift_bit(p[i]);
    latch();
    @(negedge clk);
    chk(pwm === 16'h8006, "R9 count 0", {176'b0, pwm}, {176'b0, 16'h8006});
    gs_step(3);
    chk(pwm === 16'h8002, "R8 R9 count 3", {176'b0, pwm}, {176'b0, 16'h8002});
    gs_step(4091);
    chk(pwm === 16'h0002, "R8 R9 count 4094", {176'b0, pwm}, {176'b0, 16'h0002});
    gs_step(1);
    chk(pwm === 16'h8006, "R8 wrap to 0", {176'b0, pwm}, {176'b0, 16'h8006});
    gs_step(3);
    chk(pwm === 16'h8002, "R8 count 3 again", {176'b0, pwm}, {176'b0, 16'h8002});
    @(negedge clk); blank = 1'b1;
    #1;
    chk(pwm === 16'h0000, "R10 blank forces off", {176'b0, pwm}, '0);
    gs_step(2);
    chk(pwm === 16'h0000, "R10 off while blank", {176'b0, pwm}, '0);
    @(negedge clk); blank = 1'b0;
    #1;
    chk(pwm === 16'h8006, "R10 counter restarted", {176'b0, pwm}, {176'b0, 16'h8006});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule